// File: doc/BRIEF.md
# PTP Event Timestamp Capture Unit

This block sits beside one MAC port and records when precision-time event messages pass through it. An external frame classifier flags each frame's start, its ethertype, its 4-bit message type and its 16-bit sequence number for both directions. When a frame qualifies, the unit samples a free-running 32-bit time counter on the start-of-frame cycle. It stores that time together with the sequence number in one of three capture slots: two for arrivals and one for departures.

The host reads each slot over a small register bus as four 16-bit words. These are a status word, the low and high halves of the time, and the sequence number. Writing zero to the status word frees the slot for the next capture. A slot holds a single stamp. A further qualifying frame that arrives while the slot is still full leaves the stored stamp in place and raises an overrun code. Peer-delay responses (message type 3) are sent to the second arrival slot, so that they never compete with sync or delay-request stamps.

Top module: `ptp_stamp_unit`

## Requirements
- R1: After reset every slot status word reads 0, the ethertype register (address 12) reads 0x88F7, the message-type mask (address 13) reads 0x000F, and the control register (address 14) reads 0x0003, so both disables are set.
- R2: Address map: arrival slot 0 is at addresses 0-3, arrival slot 1 at 4-7 and the departure slot at 8-11. In each slot, word +0 is status, +1 is time bits 15:0, +2 is time bits 31:16 and +3 is the sequence number. Address 15 reads 0, and reads have no side effects.
- R3: A qualifying ingress frame whose message type is not 3 is captured in arrival slot 0. The capture takes the time input on its start-of-frame cycle, and it is readable on the following cycle. The status word then reads 0x0001: bit 0 is the valid bit and bits 2:1 hold the condition code, where 0 means normal.
- R4: A qualifying ingress frame with message type 3 is captured in arrival slot 1 only, and arrival slot 0 is left unchanged.
- R5: A qualifying egress frame is captured in the departure slot, with the same word layout.
- R6: A qualifying frame for a slot that is already valid keeps the stored time and sequence number and sets the condition code to 1, so the status word reads 0x0003.
- R7: A host write of 0 to a slot's status word clears both the valid bit and the code, and the slot captures again. A non-zero write to a status word has no effect.
- R8: When a clear and a capture for the same slot land in the same cycle, the clear wins and the slot is left empty. The next qualifying frame is captured normally.
- R9: Only frames whose ethertype equals the programmable ethertype register are captured.
- R10: Bit n of the mask register enables capture of message type n, and frames whose type bit is 0 are ignored.
- R11: Control bit 0 (global disable) and control bit 1 (port disable) each block all captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_time | input | 32 | Free-running time counter |
| rx_sof | input | 1 | Ingress start-of-frame strobe |
| rx_etype | input | 16 | Ingress frame ethertype |
| rx_msg_type | input | 4 | Ingress PTP message type |
| rx_seq_id | input | 16 | Ingress PTP sequence number |
| tx_sof | input | 1 | Egress start-of-frame strobe |
| tx_etype | input | 16 | Egress frame ethertype |
| tx_msg_type | input | 4 | Egress PTP message type |
| tx_seq_id | input | 16 | Egress PTP sequence number |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational) |

## Verification
A capture driven with a start-of-frame strobe during cycle N takes the time value present at edge N. It becomes visible on the read bus right after that edge, so it is one cycle later. A register write shows up in the same way, one edge after its strobe. The bench drives each stimulus on a falling edge and lets one rising edge pass. The scoreboard then performs the expected reads, setting the address on a falling edge and sampling the combinational read data shortly after. The expected time is the bench counter's value recorded when the strobe was raised.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

    localparam int WORD_W         = 16;
    localparam int TIME_W         = 32;
    localparam int ADDR_W         = 4;
    localparam int NUM_SLOTS      = 3;
    localparam int MTYPE_W        = 4;
    localparam int SLOT_IDX_W     = 2;

    localparam logic [MTYPE_W-1:0] MTYPE_PDELAY_RESP = 4'd3;

    localparam logic [WORD_W-1:0] ETYPE_RESET = 16'h88F7;
    localparam logic [WORD_W-1:0] MASK_RESET  = 16'h000F;
    localparam logic [1:0]        CTRL_RESET  = 2'b11;

    localparam logic [ADDR_W-1:0] ADDR_ETYPE = 4'd12;
    localparam logic [ADDR_W-1:0] ADDR_MASK  = 4'd13;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 4'd14;

    localparam int SLOT_ARR0 = 0;
    localparam int SLOT_ARR1 = 1;
    localparam int SLOT_DEP  = 2;

    typedef enum logic [1:0] {
        CAP_NORMAL  = 2'd0,
        CAP_OVERRUN = 2'd1
    } cap_code_e;

    typedef struct packed {
        logic                valid;
        cap_code_e           code;
        logic [TIME_W-1:0]   stamp;
        logic [WORD_W-1:0]   seq;
    } slot_t;

    typedef struct packed {
        logic                sof;
        logic [WORD_W-1:0]   etype;
        logic [MTYPE_W-1:0]  mtype;
        logic [WORD_W-1:0]   seq;
    } frame_evt_t;

    function automatic logic [WORD_W-1:0] status_word(input slot_t s);
        return {{(WORD_W-3){1'b0}}, s.code, s.valid};
    endfunction

    function automatic logic [WORD_W-1:0] slot_word(input slot_t s,
                                                    input logic [1:0] sel);
        case (sel)
            2'd0:    return status_word(s);
            2'd1:    return s.stamp[WORD_W-1:0];
            2'd2:    return s.stamp[TIME_W-1:WORD_W];
            default: return s.seq;
        endcase
    endfunction

endpackage

// File: rtl/tsu_match.sv
module tsu_match
    import tsu_pkg::*;
(
    input  frame_evt_t          evt,
    input  logic [WORD_W-1:0]   cfg_etype,
    input  logic [WORD_W-1:0]   cfg_mask,
    input  logic                enable,
    output logic                hit
);
    logic type_on;

    always_comb begin
        type_on = cfg_mask[evt.mtype];
        hit     = enable && evt.sof && (evt.etype == cfg_etype) && type_on;
    end
endmodule

// File: rtl/tsu_slot.sv
module tsu_slot
    import tsu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                hit,
    input  logic                clr,
    input  logic [TIME_W-1:0]   stamp_in,
    input  logic [WORD_W-1:0]   seq_in,
    output slot_t               q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (clr) begin
            q.valid <= 1'b0;
            q.code  <= CAP_NORMAL;
        end else if (hit) begin
            if (!q.valid) begin
                q.valid <= 1'b1;
                q.code  <= CAP_NORMAL;
                q.stamp <= stamp_in;
                q.seq   <= seq_in;
            end else begin
                q.code  <= CAP_OVERRUN;
            end
        end
    end
endmodule

// File: rtl/ptp_stamp_unit.sv
module ptp_stamp_unit
    import tsu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [TIME_W-1:0]   cur_time,
    input  logic                rx_sof,
    input  logic [WORD_W-1:0]   rx_etype,
    input  logic [MTYPE_W-1:0]  rx_msg_type,
    input  logic [WORD_W-1:0]   rx_seq_id,
    input  logic                tx_sof,
    input  logic [WORD_W-1:0]   tx_etype,
    input  logic [MTYPE_W-1:0]  tx_msg_type,
    input  logic [WORD_W-1:0]   tx_seq_id,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata
);
    logic [WORD_W-1:0] cfg_etype;
    logic [WORD_W-1:0] cfg_mask;
    logic [1:0]        cfg_ctrl;
    logic              cap_enable;
    frame_evt_t        rx_evt, tx_evt;
    logic              rx_hit, tx_hit;
    logic [NUM_SLOTS-1:0] slot_hit;
    logic [NUM_SLOTS-1:0] slot_clr;
    slot_t             slot_q [NUM_SLOTS];
    logic [WORD_W-1:0] evt_seq [NUM_SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_etype <= ETYPE_RESET;
            cfg_mask  <= MASK_RESET;
            cfg_ctrl  <= CTRL_RESET;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_ETYPE) cfg_etype <= bus_wdata;
            if (bus_addr == ADDR_MASK)  cfg_mask  <= bus_wdata;
            if (bus_addr == ADDR_CTRL)  cfg_ctrl  <= bus_wdata[1:0];
        end
    end

    always_comb begin
        cap_enable = (cfg_ctrl == 2'b00);
        rx_evt = '{sof: rx_sof, etype: rx_etype, mtype: rx_msg_type, seq: rx_seq_id};
        tx_evt = '{sof: tx_sof, etype: tx_etype, mtype: tx_msg_type, seq: tx_seq_id};
    end

    tsu_match u_rx_match (
        .evt(rx_evt), .cfg_etype(cfg_etype), .cfg_mask(cfg_mask),
        .enable(cap_enable), .hit(rx_hit)
    );

    tsu_match u_tx_match (
        .evt(tx_evt), .cfg_etype(cfg_etype), .cfg_mask(cfg_mask),
        .enable(cap_enable), .hit(tx_hit)
    );

    always_comb begin
        slot_hit[SLOT_ARR0] = rx_hit && (rx_msg_type != MTYPE_PDELAY_RESP);
        slot_hit[SLOT_ARR1] = rx_hit && (rx_msg_type == MTYPE_PDELAY_RESP);
        slot_hit[SLOT_DEP]  = tx_hit;
        evt_seq[SLOT_ARR0]  = rx_seq_id;
        evt_seq[SLOT_ARR1]  = rx_seq_id;
        evt_seq[SLOT_DEP]   = tx_seq_id;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
            localparam logic [SLOT_IDX_W-1:0] IDX = SLOT_IDX_W'(gi);
            assign slot_clr[gi] = bus_wr && (bus_addr == {IDX, 2'b00})
                                  && (bus_wdata == '0);
            tsu_slot u_slot (
                .clk(clk), .rst(rst),
                .hit(slot_hit[gi]), .clr(slot_clr[gi]),
                .stamp_in(cur_time), .seq_in(evt_seq[gi]),
                .q(slot_q[gi])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (int'(bus_addr[ADDR_W-1:2]) < NUM_SLOTS) begin
            bus_rdata = slot_word(slot_q[bus_addr[ADDR_W-1:2]], bus_addr[1:0]);
        end else begin
            case (bus_addr)
                ADDR_ETYPE: bus_rdata = cfg_etype;
                ADDR_MASK:  bus_rdata = cfg_mask;
                ADDR_CTRL:  bus_rdata = {{(WORD_W-2){1'b0}}, cfg_ctrl};
                default:    bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tsu_capture_chk.sv
module tsu_capture_chk
    import tsu_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input slot_t                slot_q [NUM_SLOTS],
    input logic [NUM_SLOTS-1:0] hit,
    input logic [NUM_SLOTS-1:0] clr,
    input logic [1:0]           ctrl
);
    // R4
    rx_route_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit[1:0]));

    // R11
    disabled_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl != 2'b00) |-> (hit == '0));

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SLOTS; gi++) begin : g_chk
            // R7
            clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
                clr[gi] |=> (!slot_q[gi].valid && slot_q[gi].code == CAP_NORMAL));

            // R6
            keep_stamp_chk: assert property (@(posedge clk) disable iff (rst)
                (slot_q[gi].valid && !clr[gi]) |=>
                    ($stable(slot_q[gi].stamp) && $stable(slot_q[gi].seq)));

            // R6
            overrun_flag_chk: assert property (@(posedge clk) disable iff (rst)
                (slot_q[gi].valid && hit[gi] && !clr[gi]) |=>
                    (slot_q[gi].code == CAP_OVERRUN));

            // R3
            valid_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(slot_q[gi].valid) |-> $past(hit[gi]));
        end
    endgenerate
endmodule

bind ptp_stamp_unit tsu_capture_chk u_chk (
    .clk(clk), .rst(rst), .slot_q(slot_q), .hit(slot_hit),
    .clr(slot_clr), .ctrl(cfg_ctrl)
);

// File: tb/ptp_stamp_unit_test.sv
module ptp_stamp_unit_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] tcnt = 32'hA5C3_1000;
    logic        rx_sof = 0, tx_sof = 0;
    logic [15:0] rx_etype = 0, tx_etype = 0, rx_seq = 0, tx_seq = 0;
    logic [3:0]  rx_mt = 0, tx_mt = 0;
    logic [3:0]  bus_addr = 0;
    logic        bus_wr = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [3:0]  addr;
        logic [15:0] exp;
        string       tag;
    } exp_item_t;
    exp_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) tcnt <= tcnt + 32'd1;

    ptp_stamp_unit uut (
        .clk(clk), .rst(rst), .cur_time(tcnt),
        .rx_sof(rx_sof), .rx_etype(rx_etype), .rx_msg_type(rx_mt), .rx_seq_id(rx_seq),
        .tx_sof(tx_sof), .tx_etype(tx_etype), .tx_msg_type(tx_mt), .tx_seq_id(tx_seq),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    // monitor: pops expected reads and compares
    initial begin
        forever begin
            exp_item_t it;
            wait (sb_q.size() > 0);
            it = sb_q[0];
            @(negedge clk);
            bus_addr = it.addr;
            #1;
            checks++;
            if (bus_rdata !== it.exp) begin
                errors++;
                $display("FAIL %s addr=%0d actual=%h expected=%h",
                         it.tag, it.addr, bus_rdata, it.exp);
            end
            void'(sb_q.pop_front());
        end
    end

    task automatic expect_rd(input logic [3:0] a, input logic [15:0] d, input string tag);
        exp_item_t it;
        it.addr = a; it.exp = d; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic drain();
        wait (sb_q.size() == 0);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic send_rx(input logic [15:0] et, input logic [3:0] mt,
                           input logic [15:0] sq, output logic [31:0] t);
        @(negedge clk);
        rx_sof = 1; rx_etype = et; rx_mt = mt; rx_seq = sq; t = tcnt;
        @(negedge clk);
        rx_sof = 0;
    endtask

    task automatic send_tx(input logic [15:0] et, input logic [3:0] mt,
                           input logic [15:0] sq, output logic [31:0] t);
        @(negedge clk);
        tx_sof = 1; tx_etype = et; tx_mt = mt; tx_seq = sq; t = tcnt;
        @(negedge clk);
        tx_sof = 0;
    endtask

    task automatic expect_slot(input int base, input logic [15:0] st,
                               input logic [31:0] t, input logic [15:0] sq,
                               input string tag);
        expect_rd(4'(base),   st,         tag);
        expect_rd(4'(base+1), t[15:0],    tag);
        expect_rd(4'(base+2), t[31:16],   tag);
        expect_rd(4'(base+3), sq,         tag);
        drain();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] t0, t1, t2, tx0, tdummy;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset values, R2 map of config and unused address
        expect_rd(0, 16'h0000, "R1 arr0 status");
        expect_rd(4, 16'h0000, "R1 arr1 status");
        expect_rd(8, 16'h0000, "R1 dep status");
        expect_rd(12, 16'h88F7, "R1 ethertype");
        expect_rd(13, 16'h000F, "R1 mask");
        expect_rd(14, 16'h0003, "R1 control");
        expect_rd(15, 16'h0000, "R2 unused address");
        drain();

        // R11 disables block captures
        send_rx(16'h88F7, 4'd0, 16'h0001, tdummy);
        expect_rd(0, 16'h0000, "R11 both disabled");
        drain();
        wr(14, 16'h0002);
        send_rx(16'h88F7, 4'd0, 16'h0002, tdummy);
        expect_rd(0, 16'h0000, "R11 port disabled");
        drain();
        wr(14, 16'h0001);
        send_tx(16'h88F7, 4'd0, 16'h0003, tdummy);
        expect_rd(8, 16'h0000, "R11 global disabled");
        drain();
        wr(14, 16'h0000);

        // R3 capture in arrival 0
        send_rx(16'h88F7, 4'd0, 16'h1234, t0);
        expect_slot(0, 16'h0001, t0, 16'h1234, "R3 arr0 capture");
        expect_rd(4, 16'h0000, "R4 arr1 untouched by type 0");
        drain();

        // R4 peer-delay response to arrival 1
        send_rx(16'h88F7, 4'd3, 16'h0BEE, t1);
        expect_slot(4, 16'h0001, t1, 16'h0BEE, "R4 arr1 capture");
        expect_slot(0, 16'h0001, t0, 16'h1234, "R4 arr0 unchanged");

        // R6 overrun keeps earlier stamp; R2 reads repeat without side effect
        send_rx(16'h88F7, 4'd1, 16'h7777, tdummy);
        expect_slot(0, 16'h0003, t0, 16'h1234, "R6 overrun");
        expect_slot(0, 16'h0003, t0, 16'h1234, "R2 read twice");

        // R7 non-zero write ignored, zero write clears, re-arm
        wr(0, 16'h0005);
        expect_slot(0, 16'h0003, t0, 16'h1234, "R7 non-zero write ignored");
        wr(0, 16'h0000);
        expect_rd(0, 16'h0000, "R7 cleared");
        drain();
        send_rx(16'h88F7, 4'd2, 16'h4242, t2);
        expect_slot(0, 16'h0001, t2, 16'h4242, "R7 re-armed");

        // R5 departure capture
        send_tx(16'h88F7, 4'd0, 16'h55AA, tx0);
        expect_slot(8, 16'h0001, tx0, 16'h55AA, "R5 departure capture");

        // R8 clear and capture in same cycle
        @(negedge clk);
        bus_addr = 4'd8; bus_wdata = 16'h0000; bus_wr = 1;
        tx_sof = 1; tx_etype = 16'h88F7; tx_mt = 4'd1; tx_seq = 16'h9999;
        @(negedge clk);
        bus_wr = 0; tx_sof = 0;
        expect_rd(8, 16'h0000, "R8 clear wins");
        drain();
        send_tx(16'h88F7, 4'd1, 16'h6060, tx0);
        expect_slot(8, 16'h0001, tx0, 16'h6060, "R8 next capture");

        // R9 ethertype match
        wr(0, 16'h0000);
        send_rx(16'h0800, 4'd0, 16'h0101, tdummy);
        expect_rd(0, 16'h0000, "R9 wrong ethertype ignored");
        drain();
        wr(12, 16'h1234);
        expect_rd(12, 16'h1234, "R9 ethertype readback");
        drain();
        send_rx(16'h1234, 4'd0, 16'h0202, t0);
        expect_slot(0, 16'h0001, t0, 16'h0202, "R9 programmed ethertype");

        // R10 message type mask
        wr(0, 16'h0000);
        wr(13, 16'h0002);
        send_rx(16'h1234, 4'd0, 16'h0303, tdummy);
        expect_rd(0, 16'h0000, "R10 masked type ignored");
        drain();
        send_rx(16'h1234, 4'd1, 16'h0404, t0);
        expect_slot(0, 16'h0001, t0, 16'h0404, "R10 enabled type captured");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule